// File: doc/BRIEF.md
# Burst SRAM Cycle Controller

This block is the synchronous front end of a flow-through burst SRAM model, with a small behavioural array behind it. Every control input is captured on the rising clock edge. A burst begins on either of two active-low start strobes: a processor-side strobe that only acts while the primary enable is active, and a controller-side strobe that acts on its own. After a start, a 2-bit counter supplies the two low address bits. The counter moves only when the advance input is low. A static order pin picks linear or interleaved stepping.

Writes are decoded per byte lane. A global write-all input overrides the byte-write enable and the per-lane selects. A deselect takes effect at once. The read bus carries the array word at the current burst address in the cycle after the capturing edge, with no output register. The bus is driven only while the part is selected and output enable is low.

Top module: `bsram_ctl`

## Requirements
- R1: While reset is low the block is deselected and `rdrive` is 0. The counter and base address are cleared.
- R2: At an edge with `pstb_n`=0 and `en_n`=0, the block loads `addr` as the burst base and clears the counter. It is selected only if `en_hi`=1 and `en_lo_n`=0. That edge never writes, whatever the write inputs are.
- R3: At an edge with `en_n`=1, a low `pstb_n` is ignored. If `cstb_n` is also high, the edge is an ordinary continue cycle, and the base address and selection are unchanged.
- R4: At an edge with `cstb_n`=0 and no processor start, the block loads `addr`, clears the counter and samples all three enables. If any enable is inactive, the block is deselected from the next cycle. It then does not write and does not drive the bus. The secondary enables are ignored on edges without a start.
- R5: With `interleave`=0, the low two address bits are the base low bits plus the count, modulo 4. The upper bits keep the base value.
- R6: With `interleave`=1, the low two address bits are the base low bits XOR the count. The upper bits keep the base value.
- R7: On a continue edge the counter increments (wrapping 3 to 0) when `next_n`=0 and holds when `next_n`=1.
- R8: When `wall_n`=0 on a writing edge, every lane is written, whatever `wbyte_n` and `bsel_n` are.
- R9: When `wall_n`=1 and `wbyte_n`=0, only lanes whose `bsel_n` bit is 0 are written. Bit b of `bsel_n` controls `wdata[8b+7:8b]`.
- R10: When `wall_n`=1 and `wbyte_n`=1, the edge writes nothing.
- R11: `rdrive` is 1 exactly when the block is selected and `oe_n`=0. While `rdrive`=1, `rdata` is the array word at the current burst address. Otherwise `rdata` is 0.
- R12: A write on a continue edge goes to the burst address that holds after that edge, so an advancing write lands on the next address.
- R13: A controller-strobe start with all enables active writes `wdata` at the newly loaded address on that same edge, if the write inputs request it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW | External address |
| pstb_n | input | 1 | Processor-side burst start, active low |
| cstb_n | input | 1 | Controller-side burst start, active low |
| next_n | input | 1 | Burst advance, active low |
| en_n | input | 1 | Primary enable, active low |
| en_hi | input | 1 | Secondary enable, active high |
| en_lo_n | input | 1 | Secondary enable, active low |
| wall_n | input | 1 | Write all lanes, active low |
| wbyte_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | BYTES | Per-lane write selects, active low |
| oe_n | input | 1 | Output enable, active low |
| interleave | input | 1 | Burst order: 0 linear, 1 interleaved |
| wdata | input | BYTES*BYTE_W | Write data |
| rdata | output | BYTES*BYTE_W | Read data |
| rdrive | output | 1 | High while the read bus is driven |

## Verification
The assertions check the control state on every cycle:
- A processor start loads the base and clears the count.
- A blocked processor strobe leaves the base alone.
- A controller start with an inactive enable deselects the block.
- The counter holds or steps as the advance input says.
- The bus is never driven with output enable high.
- Reset leaves the bus idle.

Only the bench scenarios can show whether array contents are right. That covers lane masking, the write-all override, the write target after an advance, and both address orders. The bench compares every read with a reference array, over directed bursts and long random runs in each order.

// File: rtl/bsram_ctl.sv
module bsram_ctl #(
  parameter int AW     = 8,
  parameter int BYTES  = 2,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [AW-1:0]           addr,
  input  logic                    pstb_n,
  input  logic                    cstb_n,
  input  logic                    next_n,
  input  logic                    en_n,
  input  logic                    en_hi,
  input  logic                    en_lo_n,
  input  logic                    wall_n,
  input  logic                    wbyte_n,
  input  logic [BYTES-1:0]        bsel_n,
  input  logic                    oe_n,
  input  logic                    interleave,
  input  logic [BYTES*BYTE_W-1:0] wdata,
  output logic [BYTES*BYTE_W-1:0] rdata,
  output logic                    rdrive
);
  localparam int DW    = BYTES * BYTE_W;
  localparam int DEPTH = 1 << AW;

  logic [AW-1:0] base_q, base_d;
  logic [1:0]    cnt_q, cnt_d;
  logic          sel_q, sel_d;
  logic          wr_ok;
  logic [DW-1:0] mem [DEPTH];

  wire p_go   = !pstb_n && !en_n;
  wire c_go   = !cstb_n && !p_go;
  wire ce_all = !en_n && en_hi && !en_lo_n;

  function automatic logic [1:0] low_bits(input logic [1:0] s, input logic [1:0] c,
                                          input logic il);
    return il ? (s ^ c) : 2'(s + c);
  endfunction

  always_comb begin
    base_d = base_q;
    cnt_d  = cnt_q;
    sel_d  = sel_q;
    wr_ok  = sel_q;
    if (p_go) begin
      base_d = addr;
      cnt_d  = 2'd0;
      sel_d  = en_hi && !en_lo_n;
      wr_ok  = 1'b0;
    end else if (c_go) begin
      base_d = addr;
      cnt_d  = 2'd0;
      sel_d  = ce_all;
      wr_ok  = ce_all;
    end else if (!next_n) begin
      cnt_d = 2'(cnt_q + 2'd1);
    end
  end

  wire [AW-1:0] cur_addr = {base_q[AW-1:2], low_bits(base_q[1:0], cnt_q, interleave)};
  wire [AW-1:0] nxt_addr = {base_d[AW-1:2], low_bits(base_d[1:0], cnt_d, interleave)};

  logic [BYTES-1:0] lane_we;
  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    assign lane_we[b] = wr_ok && (!wall_n || (!wbyte_n && !bsel_n[b]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= 2'd0;
      sel_q  <= 1'b0;
    end else begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
      sel_q  <= sel_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int b = 0; b < BYTES; b++) begin
      if (lane_we[b]) mem[nxt_addr][b*BYTE_W +: BYTE_W] <= wdata[b*BYTE_W +: BYTE_W];
    end
  end

  assign rdrive = sel_q && !oe_n;
  assign rdata  = rdrive ? mem[cur_addr] : '0;
endmodule

// File: rtl/bsram_ctl_chk.sv
module bsram_ctl_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          pstb_n,
  input logic          cstb_n,
  input logic          next_n,
  input logic          en_n,
  input logic          en_hi,
  input logic          en_lo_n,
  input logic          oe_n,
  input logic          rdrive,
  input logic [AW-1:0] base_q,
  input logic [1:0]    cnt_q,
  input logic          sel_q
);
  always @(negedge clk) begin
    if (!rst_n) a_r1_reset_idle: assert (!rdrive && !sel_q && cnt_q == 2'd0);
  end

  a_r2_start_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!pstb_n && !en_n) |=> (base_q == $past(addr) && cnt_q == 2'd0));

  a_r3_ps_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (!pstb_n && en_n && cstb_n) |=> ($stable(base_q) && $stable(sel_q)));

  a_r4_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (!cstb_n && (en_n || !en_hi || en_lo_n)) |=> (!sel_q && !rdrive));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((pstb_n || en_n) && cstb_n && next_n) |=> $stable(cnt_q));

  a_r7_step: assert property (@(posedge clk) disable iff (!rst_n)
    ((pstb_n || en_n) && cstb_n && !next_n) |=> (cnt_q == 2'($past(cnt_q) + 2'd1)));

  a_r11_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !rdrive);
endmodule

bind bsram_ctl bsram_ctl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .pstb_n(pstb_n), .cstb_n(cstb_n),
  .next_n(next_n), .en_n(en_n), .en_hi(en_hi), .en_lo_n(en_lo_n), .oe_n(oe_n),
  .rdrive(rdrive), .base_q(base_q), .cnt_q(cnt_q), .sel_q(sel_q)
);

// File: tb/bsram_ctl_tb.sv
module bsram_ctl_tb;
  localparam int AW = 8, BYTES = 2, BYTE_W = 8, DW = BYTES * BYTE_W;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] addr = '0;
  logic pstb_n, cstb_n, next_n, en_n, en_hi, en_lo_n, wall_n, wbyte_n, oe_n;
  logic interleave = 0;
  logic [BYTES-1:0] bsel_n;
  logic [DW-1:0] wdata = '0, rdata;
  logic rdrive;
  int total = 0, bad = 0;

  logic [DW-1:0] refm [1<<AW];
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_cnt = '0;
  logic          m_sel = 0;

  always #10 clk = ~clk;

  bsram_ctl #(.AW(AW), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .pstb_n(pstb_n), .cstb_n(cstb_n),
    .next_n(next_n), .en_n(en_n), .en_hi(en_hi), .en_lo_n(en_lo_n), .wall_n(wall_n),
    .wbyte_n(wbyte_n), .bsel_n(bsel_n), .oe_n(oe_n), .interleave(interleave),
    .wdata(wdata), .rdata(rdata), .rdrive(rdrive));

  function automatic logic [AW-1:0] m_addr();
    logic [1:0] lo = interleave ? (m_base[1:0] ^ m_cnt) : 2'(m_base[1:0] + m_cnt);
    return {m_base[AW-1:2], lo};
  endfunction

  task automatic idle();
    pstb_n = 1; cstb_n = 1; next_n = 1; en_n = 0; en_hi = 1; en_lo_n = 0;
    wall_n = 1; wbyte_n = 1; bsel_n = '1; oe_n = 0;
  endtask

  task automatic model_edge();
    logic pg = !pstb_n && !en_n;
    logic wr;
    if (pg) begin
      m_base = addr; m_cnt = 0; m_sel = en_hi && !en_lo_n; wr = 0;
    end else if (!cstb_n) begin
      m_base = addr; m_cnt = 0; m_sel = !en_n && en_hi && !en_lo_n; wr = m_sel;
    end else begin
      if (!next_n) m_cnt = 2'(m_cnt + 2'd1);
      wr = m_sel;
    end
    if (wr) begin
      for (int b = 0; b < BYTES; b++)
        if (!wall_n || (!wbyte_n && !bsel_n[b]))
          refm[m_addr()][b*BYTE_W +: BYTE_W] = wdata[b*BYTE_W +: BYTE_W];
    end
  endtask

  task automatic check(input string tag);
    logic ed = m_sel && !oe_n;
    logic [DW-1:0] ev = ed ? refm[m_addr()] : '0;
    total++;
    if (rdrive !== ed || rdata !== ev) begin
      bad++;
      $display("FAIL %s: rdrive=%0b rdata=%h expected rdrive=%0b rdata=%h", tag, rdrive, rdata, ed, ev);
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(tag);
  endtask

  task automatic rand_run(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      pstb_n = ($urandom % 4) != 0; cstb_n = ($urandom % 4) != 0;
      next_n = $urandom % 2; en_n = ($urandom % 8) == 0;
      en_hi = ($urandom % 8) != 0; en_lo_n = ($urandom % 8) == 0;
      wall_n = ($urandom % 4) != 0; wbyte_n = $urandom % 2;
      bsel_n = BYTES'($urandom); oe_n = ($urandom % 8) == 0;
      addr = AW'($urandom); wdata = DW'($urandom);
      step(tag);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    idle();
    repeat (3) @(negedge clk);
    total++;
    if (rdrive !== 1'b0) begin bad++; $display("FAIL R1: rdrive=%0b expected 0", rdrive); end
    rst_n = 1;
    @(negedge clk);
    check("R1");

    for (int i = 0; i < (1 << AW); i++) begin
      idle(); cstb_n = 0; addr = AW'(i); wall_n = 0; wdata = DW'($urandom);
      step("R13");
    end

    idle(); pstb_n = 0; addr = 8'h25; wall_n = 0; wdata = 16'hdead; step("R2");
    idle(); step("R2");
    idle(); en_n = 1; pstb_n = 0; addr = 8'h70; step("R3");
    idle(); wall_n = 0; wbyte_n = 1; bsel_n = '1; wdata = 16'hbeef; step("R8");
    idle(); step("R8");
    idle(); wbyte_n = 0; bsel_n = 2'b10; wdata = 16'h1234; step("R9");
    idle(); step("R9");
    idle(); bsel_n = '0; wdata = 16'h5555; step("R10");

    interleave = 0;
    idle(); cstb_n = 0; addr = 8'h41; step("R5");
    for (int k = 0; k < 4; k++) begin idle(); next_n = 0; step("R5"); end
    idle(); step("R7");
    interleave = 1;
    idle(); cstb_n = 0; addr = 8'h41; step("R6");
    for (int k = 0; k < 4; k++) begin idle(); next_n = 0; step("R6"); end

    interleave = 0;
    idle(); cstb_n = 0; addr = 8'h82; wall_n = 0; wdata = 16'ha0a0; step("R13");
    idle(); next_n = 0; wall_n = 0; wdata = 16'hb1b1; step("R12");
    idle(); pstb_n = 0; addr = 8'h83; step("R12");

    idle(); cstb_n = 0; en_hi = 0; addr = 8'h10; step("R4");
    idle(); wall_n = 0; wdata = 16'h0f0f; step("R4");
    idle(); pstb_n = 0; addr = 8'h10; en_lo_n = 1; step("R4");
    idle(); pstb_n = 0; addr = 8'h10; step("R4");
    idle(); en_hi = 0; en_lo_n = 1; step("R4");
    idle(); oe_n = 1; step("R11");

    rand_run(1500, "R5");
    idle(); cstb_n = 0; en_n = 1; step("R4");
    interleave = 1;
    rand_run(1500, "R6");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule